// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for each beat of one SDRAM read or write burst. A one-cycle start pulse captures a starting column, a length code and an ordering choice. From the next cycle on, the block presents one column address per beat together with a valid flag. The beat moves forward on every cycle in which the consumer raises the advance input.

Fixed-length bursts stay inside the naturally aligned block that holds the starting column. The order within that block is either incrementing (sequential) or the start offset XORed with the beat index (interleaved). The final beat carries a last flag.

A full-page burst walks the whole row one column at a time and runs until a terminate input ends it. Asking for interleaved order on a full-page burst raises an error flag, and the burst is then generated in sequential order.

Top module: `burst_colgen`

## Requirements
- R1: A start pulse makes colValid high in the next cycle, with colOut equal to the captured startCol. A start pulse during an active burst abandons that burst, and the new burst begins in the next cycle.
- R2: lenSel selects the length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and codes 4 to 7 give a full page. The beat moves forward only on cycles where colValid and advance are both high. Otherwise colOut holds.
- R3: During a fixed burst of length L, the column bits above the low log2(L) offset bits stay equal to those of startCol. The burst wraps inside its aligned block.
- R4: With interleaved=0, beat k of a fixed burst has offset (s + k) mod L, where s is the low log2(L) bits of startCol.
- R5: With interleaved=1, beat k of a fixed burst has offset s XOR k.
- R6: With a length of 1, the only beat is startCol itself, whatever the value of interleaved, and lastBeat is high on that beat.
- R7: A full-page burst starts at startCol and adds 1 per advance, wrapping from 1023 to 0. lastBeat stays low throughout.
- R8: A full-page burst started with interleaved=1 holds modeError high while it is active. Its addresses follow sequential order.
- R9: lastBeat is high exactly on the final beat of a fixed burst. An advance on that beat makes colValid low in the next cycle.
- R10: terminate during an active burst makes colValid low in the next cycle, unless a start pulse arrives in the same cycle.
- R11: After reset, colValid, lastBeat and modeError are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | Begin a new burst |
| startCol | input | 10 | Starting column, captured on startPulse |
| lenSel | input | 3 | Burst length code |
| interleaved | input | 1 | 1 = interleaved order, 0 = sequential order |
| advance | input | 1 | Consume the current beat |
| terminate | input | 1 | End the active burst |
| colOut | output | 10 | Column address of the current beat |
| colValid | output | 1 | A burst beat is presented |
| lastBeat | output | 1 | Current beat is the final beat of a fixed burst |
| modeError | output | 1 | Active burst requested interleaved full-page order |

## Verification
The start column is due on colOut one cycle after the edge that samples startPulse. Each later address is due one cycle after the edge that samples an advance. The drop of colValid after a final advance or a terminate is also due one cycle after that edge.

The bench drives its inputs on falling edges and checks the outputs on the next falling edge, so every check sits exactly one register stage after its stimulus. Stall cycles are checked at the same point for a held address. All 1024 start columns are swept for every fixed length and both orders, with the expected address computed as block base plus the offset formula.

// File: rtl/burst_colgen_pkg.sv
package burst_colgen_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } colgen_stb_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} colgen_state_t;
endpackage

// File: rtl/burst_colgen_dp.sv
module burst_colgen_dp
  import burst_colgen_pkg::*;
#(
  parameter int COL_W = 10,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  colgen_stb_t      stb,
  input  logic [COL_W-1:0] startCol,
  input  logic [LEN_W-1:0] lenSel,
  input  logic             interleaveReq,
  output logic [COL_W-1:0] colOut,
  output logic             isFinal,
  output logic             errFlag
);
  localparam logic [LEN_W-1:0] FULL_CODE = LEN_W'(4);

  logic [COL_W-1:0] baseCol, offMask, beatCnt;
  logic [COL_W-1:0] offSeq, offIl;
  logic             ilMode, fullMode;
  logic             reqFull;
  logic [COL_W-1:0] newMask;

  always_comb begin
    reqFull = (lenSel >= FULL_CODE);
    if (reqFull) newMask = '1;
    else         newMask = COL_W'((1 << lenSel) - 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseCol  <= '0;
      offMask  <= '0;
      beatCnt  <= '0;
      ilMode   <= 1'b0;
      fullMode <= 1'b0;
      errFlag  <= 1'b0;
    end else if (stb.load) begin
      baseCol  <= startCol;
      offMask  <= newMask;
      beatCnt  <= '0;
      ilMode   <= interleaveReq && !reqFull;
      fullMode <= reqFull;
      errFlag  <= interleaveReq && reqFull;
    end else if (stb.step) begin
      beatCnt  <= beatCnt + 1'b1;
    end
  end

  always_comb begin
    offSeq  = baseCol + beatCnt;
    offIl   = baseCol ^ beatCnt;
    colOut  = (baseCol & ~offMask) | ((ilMode ? offIl : offSeq) & offMask);
    isFinal = !fullMode && (beatCnt == offMask);
  end

  assert_load_col_R1: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> colOut == $past(startCol));
  assert_block_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && !fullMode) |=> (colOut & ~offMask) == $past(colOut & ~offMask));
  assert_full_inc_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && fullMode) |=> colOut == $past(colOut) + 1'b1);
  assert_err_seq_R8: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (fullMode && !ilMode));
endmodule

// File: rtl/burst_colgen_ctrl.sv
module burst_colgen_ctrl
  import burst_colgen_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic        advance,
  input  logic        terminate,
  input  logic        isFinal,
  output colgen_stb_t stb,
  output logic        active,
  output logic        lastBeat
);
  colgen_state_t state, stateNext;

  always_comb begin
    stateNext = state;
    if (startPulse) stateNext = ST_RUN;
    else if (state == ST_RUN && (terminate || (advance && isFinal)))
      stateNext = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    active   = (state == ST_RUN);
    stb.load = startPulse;
    stb.step = active && advance && !startPulse;
    lastBeat = active && isFinal;
  end

  assert_start_run_R1: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> active);
  assert_final_end_R9: assert property (@(posedge clk) disable iff (!rstN)
    (active && advance && isFinal && !startPulse) |=> !active);
  assert_term_end_R10: assert property (@(posedge clk) disable iff (!rstN)
    (active && terminate && !startPulse) |=> !active);
  assert_idle_stays_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !startPulse) |=> !active);
endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
  import burst_colgen_pkg::*;
#(
  parameter int COL_W = 10,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [COL_W-1:0] startCol,
  input  logic [LEN_W-1:0] lenSel,
  input  logic             interleaved,
  input  logic             advance,
  input  logic             terminate,
  output logic [COL_W-1:0] colOut,
  output logic             colValid,
  output logic             lastBeat,
  output logic             modeError
);
  colgen_stb_t stb;
  logic        isFinal, active, errFlag;

  burst_colgen_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .advance(advance),
    .terminate(terminate), .isFinal(isFinal), .stb(stb), .active(active),
    .lastBeat(lastBeat)
  );

  burst_colgen_dp #(.COL_W(COL_W), .LEN_W(LEN_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .startCol(startCol), .lenSel(lenSel),
    .interleaveReq(interleaved), .colOut(colOut), .isFinal(isFinal),
    .errFlag(errFlag)
  );

  assign colValid  = active;
  assign modeError = active && errFlag;

  assert_last_needs_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> colValid);
endmodule

// File: tb/burst_colgen_tb_top.sv
module burst_colgen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startPulse = 1'b0;
  logic [9:0] startCol = '0;
  logic [2:0] lenSel = '0;
  logic       interleaved = 1'b0;
  logic       advance = 1'b0;
  logic       terminate = 1'b0;
  logic [9:0] colOut;
  logic       colValid, lastBeat, modeError;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_colgen dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .startCol(startCol),
    .lenSel(lenSel), .interleaved(interleaved), .advance(advance),
    .terminate(terminate), .colOut(colOut), .colValid(colValid),
    .lastBeat(lastBeat), .modeError(modeError)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expCol(input int s, input int lenCode, input bit il, input int k);
    int mask;
    int off;
    mask = (lenCode >= 4) ? 1023 : ((1 << lenCode) - 1);
    off  = (il && lenCode < 4) ? (s ^ k) : (s + k);
    return (s & ~mask & 1023) | (off & mask);
  endfunction

  task automatic startBurst(input int s, input int lenCode, input bit il);
    @(negedge clk);
    startPulse  = 1'b1;
    startCol    = 10'(s);
    lenSel      = 3'(lenCode);
    interleaved = il;
    advance     = 1'b0;
    @(negedge clk);
    startPulse  = 1'b0;
  endtask

  task automatic fixedBurst(input int s, input int lenCode, input bit il);
    int L;
    string tagO;
    L = 1 << lenCode;
    tagO = (lenCode == 0) ? "R6" : (il ? "R5" : "R4");
    startBurst(s, lenCode, il);
    chk(colValid === 1'b1, "R1 valid", int'(colValid), 1);
    for (int k = 0; k < L; k++) begin
      chk(colOut === 10'(expCol(s, lenCode, il, k)), tagO, int'(colOut), expCol(s, lenCode, il, k));
      chk((colOut >> lenCode) === (10'(s) >> lenCode), "R3 block", int'(colOut), s);
      chk(lastBeat === (k == L - 1), "R9 last", int'(lastBeat), int'(k == L - 1));
      if (k == 0 && s[0] && L > 1) begin
        advance = 1'b0;
        @(negedge clk);
        chk(colOut === 10'(expCol(s, lenCode, il, 0)), "R2 hold", int'(colOut), expCol(s, lenCode, il, 0));
      end
      advance = 1'b1;
      @(negedge clk);
    end
    advance = 1'b0;
    chk(colValid === 1'b0, "R9 end", int'(colValid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(colValid === 1'b0, "R11 valid", int'(colValid), 0);
    chk(lastBeat === 1'b0, "R11 last", int'(lastBeat), 0);
    chk(modeError === 1'b0, "R11 err", int'(modeError), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(colValid === 1'b0, "R2 idle", int'(colValid), 0);

    for (int lc = 0; lc < 4; lc++)
      for (int il = 0; il < 2; il++)
        for (int s = 0; s < 1024; s++)
          fixedBurst(s, lc, il[0]);

    // R7, R8: full page from near the top of the row, both order requests
    for (int il = 0; il < 2; il++) begin
      startBurst(1019, 4 + 3 * il, il[0]);
      for (int k = 0; k < 10; k++) begin
        chk(colOut === 10'((1019 + k) % 1024), "R7 full", int'(colOut), (1019 + k) % 1024);
        chk(lastBeat === 1'b0, "R7 nolast", int'(lastBeat), 0);
        chk(modeError === il[0], "R8 err", int'(modeError), il);
        advance = 1'b1;
        @(negedge clk);
      end
      advance = 1'b0;
      terminate = 1'b1;
      @(negedge clk);
      terminate = 1'b0;
      chk(colValid === 1'b0, "R10 term", int'(colValid), 0);
      chk(modeError === 1'b0, "R8 clear", int'(modeError), 0);
    end

    // R1: restart during an active burst
    startBurst(3, 3, 1'b0);
    advance = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(colOut === 10'd5, "R4 pre-abort", int'(colOut), 5);
    startPulse = 1'b1; startCol = 10'd102; lenSel = 3'd2; interleaved = 1'b1; advance = 1'b0;
    @(negedge clk);
    startPulse = 1'b0;
    chk(colOut === 10'd102, "R1 restart", int'(colOut), 102);
    chk(colValid === 1'b1, "R1 restart valid", int'(colValid), 1);
    advance = 1'b1;
    @(negedge clk);
    chk(colOut === 10'd103, "R5 after restart", int'(colOut), 103);
    @(negedge clk);
    chk(colOut === 10'd100, "R5 after restart", int'(colOut), 100);

    // R10: start wins over terminate in the same cycle
    startPulse = 1'b1; terminate = 1'b1; startCol = 10'd7; lenSel = 3'd1; interleaved = 1'b0; advance = 1'b0;
    @(negedge clk);
    startPulse = 1'b0; terminate = 1'b0;
    chk(colValid === 1'b1, "R10 start wins", int'(colValid), 1);
    chk(colOut === 10'd7, "R1 start col", int'(colOut), 7);
    terminate = 1'b1;
    @(negedge clk);
    terminate = 1'b0;
    chk(colValid === 1'b0, "R10 fixed term", int'(colValid), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule